// File: doc/BRIEF.md
# Clock Frequency Window Watchdog

This block watches a fast module clock and reports when its frequency drifts outside a window given by two 6-bit thresholds. A slow counter in an independent reference clock domain marks out a measurement gate of 2^GATE_LOG2 reference periods. The gate boundary is carried into the fast domain as a toggle through a two-flop synchronizer. There, a counter of fast cycles is sampled and restarted on every boundary. The sampled count is scaled to threshold units, where one unit is one thirty-second of the reference frequency, and it saturates at 127. A limit therefore sits at `threshold * f_ref / 32`. Because the reference runs free and may be off by up to ±20%, both limits move with it by the same proportion.

Each finished measurement is compared with the upper and lower threshold. A single reading outside the window only arms the matching detector. A second reading outside the window on the same side raises a sticky flag. A reading that lies inside the window by at least the hysteresis amount disarms the detector. A reading in the hysteresis band next to a limit leaves the detector as it was. While `en` is low, counting stops and both detectors disarm. The first boundary after reset or after enabling only restarts the count, so that partial reading is thrown away. The flags stay set until `clr` is driven, and a new fault in the same cycle takes precedence over the clear.

Top module: `clkwin_mon`

## Requirements
- R1: After reset both `ov_flag` and `un_flag` read 0.
- R2: A measurement equals the number of fast cycles in 32 reference periods. When it lies in the inclusive range `lo_th`..`up_th`, neither flag is raised.
- R3: Two consecutive valid measurements above `up_th` set `ov_flag` and leave `un_flag` at 0.
- R4: Two consecutive valid measurements below `lo_th` set `un_flag` and leave `ov_flag` at 0.
- R5: With `lo_th` = 0, `un_flag` never sets, however slow the fast clock is.
- R6: Measurements saturate at 127 rather than wrapping, so a fast clock of more than 127 units still sets `ov_flag` when `up_th` = 63.
- R7: The first boundary after reset or after `en` rises produces no measurement. A single valid out-of-window measurement after enabling sets no flag.
- R8: An armed detector is disarmed only by a measurement at or below `up_th - hyst` (over side) or at or above `lo_th + hyst` (under side). A measurement between that point and the limit keeps it armed.
- R9: An out-of-window measurement followed by one that is clearly inside the window sets no flag.
- R10: Flags stay set while `clr` is low and go to 0 one fast cycle after `clr` is high in a cycle with no new fault.
- R11: When a fault is detected in the same cycle that `clr` is high, the flag is set.
- R12: Limits follow the reference frequency. A reference period 20% longer raises the measurement by 20%, and one 20% shorter lowers it by 20%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Supervised fast clock |
| rclk | input | 1 | Independent reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en | input | 1 | Measurement enable (fast domain) |
| up_th | input | 6 | Upper threshold in units of f_ref/32 |
| lo_th | input | 6 | Lower threshold in units of f_ref/32 |
| hyst | input | HYST_W | Hysteresis in threshold units for disarming |
| clr | input | 1 | Clears both sticky flags (fast domain) |
| ov_flag | output | 1 | Sticky over-frequency flag |
| un_flag | output | 1 | Sticky under-frequency flag |

## Verification
A measurement can finish in the same fast cycle in which software is clearing the flags, so the set path and the clear path meet in the same cycle. The bench holds `clr` high through several measurements of a clock that is too fast. It then checks that `ov_flag` was seen high in at least one sampled cycle. Under clear-wins priority the flag would never show. The bench also places the reference clock's period changes exactly on gate boundaries, so that band readings and disarming readings come in a chosen order.

// File: rtl/clkwin_mon.sv
module clkwin_mon #(
  parameter int GATE_LOG2 = 5,
  parameter int CNT_W     = 12,
  parameter int HYST_W    = 2
) (
  input  logic              fclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [5:0]        up_th,
  input  logic [5:0]        lo_th,
  input  logic [HYST_W-1:0] hyst,
  input  logic              clr,
  output logic              ov_flag,
  output logic              un_flag
);
  localparam int TH_W      = 6;
  localparam int UNIT_LOG2 = 5;
  localparam int MEAS_W    = TH_W + 1;
  localparam int GC_W      = (GATE_LOG2 < 1) ? 1 : GATE_LOG2;
  localparam int SC_W      = CNT_W + UNIT_LOG2;
  localparam int CMP_W     = ((HYST_W > MEAS_W) ? HYST_W : MEAS_W) + 1;
  localparam logic [MEAS_W-1:0] MEAS_MAX = '1;

  // reference domain: free-running gate, boundary as a toggle
  logic [GC_W-1:0] gcnt;
  logic            gtgl;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0;
      gtgl <= 1'b0;
    end else begin
      gcnt <= gcnt + 1'b1;
      if (&gcnt) gtgl <= ~gtgl;
    end
  end

  // fast domain: synchronize the toggle, detect its change
  logic [2:0] gsync;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) gsync <= '0;
    else        gsync <= {gsync[1:0], gtgl};
  end

  wire gedge = gsync[2] ^ gsync[1];

  logic [CNT_W-1:0] fcnt;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n)          fcnt <= '0;
    else if (!en)        fcnt <= '0;
    else if (gedge)      fcnt <= CNT_W'(1);
    else if (!(&fcnt))   fcnt <= fcnt + 1'b1;
  end

  logic [SC_W-1:0] scaled;

  generate
    if (GATE_LOG2 >= UNIT_LOG2) begin : g_down
      assign scaled = SC_W'(fcnt >> (GATE_LOG2 - UNIT_LOG2));
    end else begin : g_up
      assign scaled = SC_W'(fcnt) << (UNIT_LOG2 - GATE_LOG2);
    end
  endgenerate

  wire [MEAS_W-1:0] meas_d = (scaled > SC_W'(MEAS_MAX)) ? MEAS_MAX : scaled[MEAS_W-1:0];

  logic [MEAS_W-1:0] meas;
  logic              meas_vld;
  logic              skip;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      meas     <= '0;
      meas_vld <= 1'b0;
      skip     <= 1'b1;
    end else begin
      meas_vld <= 1'b0;
      if (!en) begin
        skip <= 1'b1;
      end else if (gedge) begin
        if (skip) begin
          skip <= 1'b0;
        end else begin
          meas     <= meas_d;
          meas_vld <= 1'b1;
        end
      end
    end
  end

  // window compare with two-hit arming and hysteresis
  logic ov_arm, un_arm;

  wire [CMP_W-1:0] m_x  = CMP_W'(meas);
  wire [CMP_W-1:0] up_x = CMP_W'(up_th);
  wire [CMP_W-1:0] lo_x = CMP_W'(lo_th);
  wire [CMP_W-1:0] h_x  = CMP_W'(hyst);

  wire ov_out = m_x > up_x;
  wire ov_in  = (m_x + h_x) <= up_x;
  wire un_out = m_x < lo_x;
  wire un_in  = m_x >= (lo_x + h_x);

  wire ov_hit = meas_vld & ov_out & ov_arm;
  wire un_hit = meas_vld & un_out & un_arm;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      ov_arm <= 1'b0;
      un_arm <= 1'b0;
    end else if (!en) begin
      ov_arm <= 1'b0;
      un_arm <= 1'b0;
    end else if (meas_vld) begin
      if (ov_out)     ov_arm <= 1'b1;
      else if (ov_in) ov_arm <= 1'b0;
      if (un_out)     un_arm <= 1'b1;
      else if (un_in) un_arm <= 1'b0;
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      ov_flag <= 1'b0;
      un_flag <= 1'b0;
    end else begin
      ov_flag <= ov_hit | (ov_flag & ~clr);
      un_flag <= un_hit | (un_flag & ~clr);
    end
  end

endmodule

// File: rtl/clkwin_mon_chk.sv
module clkwin_mon_chk (
  input logic       fclk,
  input logic       rst_n,
  input logic       clr,
  input logic [5:0] up_th,
  input logic [5:0] lo_th,
  input logic       ov_flag,
  input logic       un_flag,
  input logic       meas_vld,
  input logic [6:0] meas
);
  // R3: a rising over flag follows a measurement above the upper threshold
  a_r3_ov_cause: assert property (@(posedge fclk) disable iff (!rst_n)
    $rose(ov_flag) |-> ($past(meas_vld) && ($past(meas) > {1'b0, $past(up_th)})));

  // R4: a rising under flag follows a measurement below the lower threshold
  a_r4_un_cause: assert property (@(posedge fclk) disable iff (!rst_n)
    $rose(un_flag) |-> ($past(meas_vld) && ($past(meas) < {1'b0, $past(lo_th)})));

  // R5: a zero lower threshold never lets the under flag rise
  a_r5_zero_low: assert property (@(posedge fclk) disable iff (!rst_n)
    (lo_th == 6'd0 && !un_flag) |=> !un_flag);

  // R10: flags hold while no clear is applied
  a_r10_hold_ov: assert property (@(posedge fclk) disable iff (!rst_n)
    (ov_flag && !clr) |=> ov_flag);
  a_r10_hold_un: assert property (@(posedge fclk) disable iff (!rst_n)
    (un_flag && !clr) |=> un_flag);

  // R10: a clear with no measurement completing empties both flags
  a_r10_clear: assert property (@(posedge fclk) disable iff (!rst_n)
    (clr && !meas_vld) |=> (!ov_flag && !un_flag));

  // R7: flags only rise right after a measurement is taken
  a_r7_rise_after_meas: assert property (@(posedge fclk) disable iff (!rst_n)
    ($rose(ov_flag) || $rose(un_flag)) |-> $past(meas_vld));
endmodule

bind clkwin_mon clkwin_mon_chk u_chk (
  .fclk     (fclk),
  .rst_n    (rst_n),
  .clr      (clr),
  .up_th    (up_th),
  .lo_th    (lo_th),
  .ov_flag  (ov_flag),
  .un_flag  (un_flag),
  .meas_vld (meas_vld),
  .meas     (meas)
);

// File: tb/test_clkwin_mon.sv
`timescale 1ns/1ps
module test_clkwin_mon;
  logic       fclk = 1'b0;
  logic       rclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       clr = 1'b0;
  logic [5:0] up_th = 6'd63;
  logic [5:0] lo_th = 6'd0;
  logic [1:0] hyst = 2'd0;
  wire        ov_flag, un_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  clkwin_mon i_clkwin_mon (
    .fclk(fclk), .rclk(rclk), .rst_n(rst_n), .en(en),
    .up_th(up_th), .lo_th(lo_th), .hyst(hyst), .clr(clr),
    .ov_flag(ov_flag), .un_flag(un_flag)
  );

  always #5 fclk = ~fclk;

  // reference clock; period changes land exactly on gate boundaries (32 edges)
  real  rper = 12.5;
  real  rper_next = 12.5;
  int   redges = 0;
  event gate_ev;

  initial forever begin
    #(rper / 2.0) rclk = 1'b1;
    if (rst_n) begin
      redges++;
      if (redges % 32 == 0) begin
        rper = rper_next;
        -> gate_ev;
      end
    end
    #(rper / 2.0) rclk = 1'b0;
  end

  // scoreboard: driver pushes expected flag pairs, monitor compares
  string      tag_q[$];
  logic [1:0] exp_q[$];

  always @(negedge fclk) begin
    if (tag_q.size() != 0) begin
      string      t;
      logic [1:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if ({ov_flag, un_flag} !== e) begin
        failures++;
        $display("FAIL %s: ov=%0b un=%0b expected ov=%0b un=%0b", t, ov_flag, un_flag, e[1], e[0]);
      end
    end
  end

  bit watch_clr = 0;
  int ov_seen = 0;
  always @(negedge fclk) if (watch_clr && ov_flag) ov_seen++;

  task automatic expect_flags(input string t, input logic ov, input logic un);
    tag_q.push_back(t);
    exp_q.push_back({ov, un});
    @(negedge fclk);
    @(negedge fclk);
  endtask

  task automatic check_cond(input string t, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  task automatic run_gate(input real per);
    rper_next = per;
    @(gate_ev);
    @(negedge fclk);
  endtask

  task automatic start(input real per, input logic [5:0] u, input logic [5:0] l, input logic [1:0] h);
    en = 1'b0;
    clr = 1'b1;
    up_th = u;
    lo_th = l;
    hyst = h;
    run_gate(per);
    en = 1'b1;
    clr = 1'b0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #101 rst_n = 1'b1;
    @(negedge fclk);
    expect_flags("R1 reset", 1'b0, 1'b0);

    // R2: m=40 inside 30..50
    start(12.5, 6'd50, 6'd30, 2'd0);
    run_gate(12.5); run_gate(12.5); run_gate(12.5);
    #100 expect_flags("R2 in window", 1'b0, 1'b0);

    // R3: m=40 above 30
    start(12.5, 6'd30, 6'd10, 2'd0);
    run_gate(12.5); run_gate(12.5); run_gate(12.5);
    #100 expect_flags("R3 over", 1'b1, 1'b0);

    // R7 then R4: m=40 below 50
    start(12.5, 6'd63, 6'd50, 2'd0);
    run_gate(12.5);
    #100 expect_flags("R7 one valid measurement only", 1'b0, 1'b0);
    run_gate(12.5);
    #100 expect_flags("R4 under", 1'b0, 1'b1);

    // R5: m=4 with zero lower threshold, then with 10
    start(1.25, 6'd63, 6'd0, 2'd0);
    run_gate(1.25); run_gate(1.25); run_gate(1.25);
    #100 expect_flags("R5 zero low threshold", 1'b0, 1'b0);
    start(1.25, 6'd63, 6'd10, 2'd0);
    run_gate(1.25); run_gate(1.25); run_gate(1.25);
    #100 expect_flags("R5 contrast low=10", 1'b0, 1'b1);

    // R6: m=160 saturates to 127 > 63
    start(50.0, 6'd63, 6'd40, 2'd0);
    run_gate(50.0); run_gate(50.0); run_gate(12.5);
    #100 expect_flags("R6 saturation", 1'b1, 1'b0);

    // R12: window 35..45, reference nominal, +20%, -20%
    start(12.5, 6'd45, 6'd35, 2'd0);
    run_gate(12.5); run_gate(12.5); run_gate(12.5);
    #100 expect_flags("R12 nominal m=40", 1'b0, 1'b0);
    start(15.0, 6'd45, 6'd35, 2'd0);
    run_gate(15.0); run_gate(15.0); run_gate(12.5);
    #100 expect_flags("R12 slow ref m=48", 1'b1, 1'b0);
    start(10.0, 6'd45, 6'd35, 2'd0);
    run_gate(10.0); run_gate(10.0); run_gate(12.5);
    #100 expect_flags("R12 fast ref m=32", 1'b0, 1'b1);

    // R8: out(46), band(39), out(46) with up=40 hyst=3 -> armed held
    start(14.375, 6'd40, 6'd0, 2'd3);
    run_gate(12.1875); run_gate(14.375); run_gate(9.375);
    #100 expect_flags("R8 band keeps arm", 1'b1, 1'b0);
    start(14.375, 6'd40, 6'd0, 2'd0);
    run_gate(12.1875); run_gate(14.375); run_gate(9.375);
    #100 expect_flags("R8 no hysteresis disarms", 1'b0, 1'b0);

    // R9: out(46), clear(30), out(46), clear(30)
    start(14.375, 6'd40, 6'd0, 2'd3);
    run_gate(9.375); run_gate(14.375); run_gate(9.375); run_gate(9.375);
    #100 expect_flags("R9 isolated glitches", 1'b0, 1'b0);

    // R10: set, then in-window readings, flag stays; then clear
    start(12.5, 6'd30, 6'd10, 2'd0);
    run_gate(12.5); run_gate(6.25); run_gate(6.25);
    #100 expect_flags("R10 sticky", 1'b1, 1'b0);
    clr = 1'b1;
    @(negedge fclk);
    clr = 1'b0;
    expect_flags("R10 cleared", 1'b0, 1'b0);

    // R11: clear held while faults arrive
    start(12.5, 6'd30, 6'd10, 2'd0);
    clr = 1'b1;
    watch_clr = 1;
    run_gate(12.5); run_gate(12.5); run_gate(12.5);
    #100;
    watch_clr = 0;
    check_cond("R11 set beats clear", ov_seen > 0, ov_seen, 1);
    clr = 1'b0;
    expect_flags("R11 clear quiet after", 1'b0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule